// File: doc/BRIEF.md
# Write-Masked PHY Control Register Bank

This block holds the control words that steer a receive-side serial camera PHY: lane enables, forced-mode controls, turnaround controls, clock inversion selects, a second transceiver's setup bits and a bit-banged test port. Software writes a 32-bit word whose upper halfword is a per-bit write enable for the lower halfword. A single field can therefore be changed in one write, with no read-modify-write. Each field drives its own output pin.

One further address is a read-only status word that returns the PHY's 8-bit test data output. A read returns the lower halfword of the addressed word, with the upper halfword as zero. A write to an address that no word occupies changes nothing and raises a one-cycle decode-error flag.

The number of lanes per lane field is a parameter of 1 to 4. The nibble layout of the lane word stays fixed, and the lane bits that are not built read as zero.

Top module: `phy_ctl_regbank`

## Requirements
- R1: On a write to a control word, bit n (0..15) takes bit n of the written data only when bit n+16 is 1. All other bits keep their value. Bits that are not implemented always read 0.
- R2: Address 0 is the lane word. `lane_en` is at bit 0, `force_rx` at bit 4, `force_stop` at bit 8 and `turn_dis` at bit 12. Each field is LANES bits wide inside a 4-bit nibble.
- R3: Address 1 holds `turn_req` (LANES bits at bit 0), `clk_inv[0]` at bit 10 and `clk_inv[1]` at bit 11.
- R4: Address 2 holds `xcv_turn_req` (LANES bits at bit 0), `xcv_src_sel` at bit 4, `xcv_base_dir` at bit 5, `xcv_clk_en` at bit 6 and `xcv_master` at bit 7.
- R5: Address 3 holds `test_din` (bits 7:0), `test_en` (bit 8), `test_clk` (bit 9) and `test_clr` (bit 10).
- R6: Address 4 is a status word. A read of it returns `test_dout` in bits 7:0, with every other bit 0. A write to it changes nothing and raises no decode error.
- R7: A read loads `rd_data` at the clock edge where `rd_valid` is high. The value appears the cycle after and is held until the next read. Bits 31:16 are always 0. A read of an unmapped address (5 to 7) returns 0.
- R8: After reset every field is 0 except `test_clk`, which is 1. Address 3 therefore reads 0x00000200.
- R9: A write to an unmapped address changes no register. `dec_err` is high for exactly the one cycle after that write and low otherwise.
- R10: Output fields change at the clock edge that accepts the write. A read of the same word in the same cycle returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write mask (31:16) and data (15:0) |
| rd_valid | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Registered read data |
| dec_err | output | 1 | Unmapped write seen in the previous cycle |
| test_dout | input | 8 | PHY test data output |
| lane_en | output | LANES | Data lane enables |
| force_rx | output | LANES | Force receive mode per lane |
| force_stop | output | LANES | Force stop state per lane |
| turn_dis | output | LANES | Turnaround disable per lane |
| turn_req | output | LANES | Turnaround request per lane |
| clk_inv | output | 2 | Receiver clock inversion selects |
| xcv_turn_req | output | LANES | Second transceiver turnaround request |
| xcv_src_sel | output | 1 | Second transceiver source select |
| xcv_base_dir | output | 1 | Second transceiver base direction |
| xcv_clk_en | output | 1 | Second transceiver clock enable |
| xcv_master | output | 1 | Second transceiver master (1) or slave (0) |
| test_din | output | 8 | Test port data in |
| test_en | output | 1 | Test port enable |
| test_clk | output | 1 | Test port clock |
| test_clr | output | 1 | Test port clear |

## Verification
Every stored bit drives an output pin directly. A masking or decode fault therefore shows at a field output on the cycle right after the faulty write, and in `rd_data` one cycle after a readback. The stimulus mixes full masks, single-field masks and zero masks, so that a write that ignores its enables, or that leaks into a neighbouring word or into reserved bits, leaves a value that differs from the expected one. The status word, the unmapped addresses and a same-cycle read and write are checked directly, because a decode slip there leaves every normal field correct.

// File: rtl/phyctl_pkg.sv
package phyctl_pkg;
   localparam int unsigned HALF_W   = 16;
   localparam int unsigned NUM_CTL  = 4;
   localparam int unsigned ADR_LANE = 0;
   localparam int unsigned ADR_TURN = 1;
   localparam int unsigned ADR_XCV  = 2;
   localparam int unsigned ADR_TEST = 3;
   localparam int unsigned ADR_STAT = 4;

   // implemented bits of control word idx for a given lane count
   function automatic logic [HALF_W-1:0] impl_mask(input int unsigned idx, input int unsigned lanes);
      logic [HALF_W-1:0] lm;
      lm = HALF_W'((1 << lanes) - 1);
      case (idx)
         ADR_LANE: impl_mask = lm | (lm << 4) | (lm << 8) | (lm << 12);
         ADR_TURN: impl_mask = lm | 16'h0C00;
         ADR_XCV:  impl_mask = lm | 16'h00F0;
         default:  impl_mask = 16'h07FF;
      endcase
   endfunction

   function automatic logic [HALF_W-1:0] rst_value(input int unsigned idx);
      rst_value = (idx == ADR_TEST) ? 16'h0200 : 16'h0000;
   endfunction
endpackage

// File: rtl/phyctl_mask_reg.sv
module phyctl_mask_reg #(
   parameter int unsigned W = 16,
   parameter logic [W-1:0] IMPL = '1,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wmask,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   logic [W-1:0] en;
   assign en = wmask & IMPL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST & IMPL;
      else if (we) q <= (q & ~en) | (wdata & en);
   end

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (((q ^ $past(q)) & ~$past(wmask)) == '0)); // R1
   AST_MASK_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (((q ^ $past(wdata)) & $past(wmask) & IMPL) == '0)); // R1
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q)); // R9
endmodule

// File: rtl/phyctl_rd_mux.sv
module phyctl_rd_mux
   import phyctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 32
) (
   input  logic [NUM_CTL*HALF_W-1:0] ctl_flat,
   input  logic [7:0]                stat_in,
   input  logic [ADDR_W-1:0]         addr,
   output logic [DATA_W-1:0]         word
);
   always_comb begin
      word = '0;
      for (int unsigned k = 0; k < NUM_CTL; k++) begin
         if (addr == ADDR_W'(k)) word[HALF_W-1:0] = ctl_flat[k*HALF_W +: HALF_W];
      end
      if (addr == ADDR_W'(ADR_STAT)) word[7:0] = stat_in;
   end
endmodule

// File: rtl/phy_ctl_regbank.sv
module phy_ctl_regbank
   import phyctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_valid,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              dec_err,
   input  logic [7:0]        test_dout,
   output logic [LANES-1:0]  lane_en,
   output logic [LANES-1:0]  force_rx,
   output logic [LANES-1:0]  force_stop,
   output logic [LANES-1:0]  turn_dis,
   output logic [LANES-1:0]  turn_req,
   output logic [1:0]        clk_inv,
   output logic [LANES-1:0]  xcv_turn_req,
   output logic              xcv_src_sel,
   output logic              xcv_base_dir,
   output logic              xcv_clk_en,
   output logic              xcv_master,
   output logic [7:0]        test_din,
   output logic              test_en,
   output logic              test_clk,
   output logic              test_clr
);
   localparam int unsigned MASK_LSB = DATA_W / 2;

   if (DATA_W != 2 * HALF_W) begin : g_bad_width
      $error("phy_ctl_regbank: DATA_W must be 32");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("phy_ctl_regbank: ADDR_W must be at least 3");
   end
   if (LANES < 1 || LANES > 4) begin : g_bad_lanes
      $error("phy_ctl_regbank: LANES must be 1..4");
   end

   logic [NUM_CTL*HALF_W-1:0] ctl_flat;
   logic [DATA_W-1:0]         rd_word;
   logic                      wr_unmapped;

   assign wr_unmapped = wr_addr > ADDR_W'(ADR_STAT);

   for (genvar i = 0; i < NUM_CTL; i++) begin : g_ctl
      logic [HALF_W-1:0] q;
      phyctl_mask_reg #(
         .W(HALF_W),
         .IMPL(impl_mask(i, LANES)),
         .RST(rst_value(i))
      ) i_reg (
         .clk(clk),
         .rst_n(rst_n),
         .we(wr_valid && (wr_addr == ADDR_W'(i))),
         .wmask(wr_data[MASK_LSB +: HALF_W]),
         .wdata(wr_data[HALF_W-1:0]),
         .q(q)
      );
      assign ctl_flat[i*HALF_W +: HALF_W] = q;
   end

   phyctl_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rd_mux (
      .ctl_flat(ctl_flat),
      .stat_in(test_dout),
      .addr(rd_addr),
      .word(rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         dec_err <= 1'b0;
      end else begin
         if (rd_valid) rd_data <= rd_word;
         dec_err <= wr_valid && wr_unmapped;
      end
   end

   // field breakout
   assign lane_en      = g_ctl[ADR_LANE].q[0  +: LANES];
   assign force_rx     = g_ctl[ADR_LANE].q[4  +: LANES];
   assign force_stop   = g_ctl[ADR_LANE].q[8  +: LANES];
   assign turn_dis     = g_ctl[ADR_LANE].q[12 +: LANES];
   assign turn_req     = g_ctl[ADR_TURN].q[0  +: LANES];
   assign clk_inv      = g_ctl[ADR_TURN].q[11:10];
   assign xcv_turn_req = g_ctl[ADR_XCV].q[0 +: LANES];
   assign xcv_src_sel  = g_ctl[ADR_XCV].q[4];
   assign xcv_base_dir = g_ctl[ADR_XCV].q[5];
   assign xcv_clk_en   = g_ctl[ADR_XCV].q[6];
   assign xcv_master   = g_ctl[ADR_XCV].q[7];
   assign test_din     = g_ctl[ADR_TEST].q[7:0];
   assign test_en      = g_ctl[ADR_TEST].q[8];
   assign test_clk     = g_ctl[ADR_TEST].q[9];
   assign test_clr     = g_ctl[ADR_TEST].q[10];

   AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[DATA_W-1:MASK_LSB] == '0); // R7
   AST_STAT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_addr == ADDR_W'(ADR_STAT)) |=> (rd_data == DATA_W'($past(test_dout)))); // R6
   AST_STAT_WR_NOERR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_addr == ADDR_W'(ADR_STAT)) |=> !dec_err); // R6
   AST_DECERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      dec_err |-> $past(wr_valid)); // R9
endmodule

// File: tb/test_phy_ctl_regbank.sv
module test_phy_ctl_regbank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_valid = 1'b0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        dec_err;
   logic [7:0]  test_dout = '0;
   logic [3:0]  lane_en, force_rx, force_stop, turn_dis, turn_req, xcv_turn_req;
   logic [1:0]  clk_inv;
   logic        xcv_src_sel, xcv_base_dir, xcv_clk_en, xcv_master;
   logic [7:0]  test_din;
   logic        test_en, test_clk, test_clr;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   phy_ctl_regbank i_phy_ctl_regbank (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .dec_err(dec_err),
      .test_dout(test_dout), .lane_en(lane_en), .force_rx(force_rx), .force_stop(force_stop),
      .turn_dis(turn_dis), .turn_req(turn_req), .clk_inv(clk_inv), .xcv_turn_req(xcv_turn_req),
      .xcv_src_sel(xcv_src_sel), .xcv_base_dir(xcv_base_dir), .xcv_clk_en(xcv_clk_en),
      .xcv_master(xcv_master), .test_din(test_din), .test_en(test_en), .test_clk(test_clk),
      .test_clr(test_clr)
   );

   // {addr, write word, expected readback}
   localparam logic [66:0] VEC [9] = '{
      {3'd0, 32'hFFFF_A5C3, 32'h0000_A5C3},  // R1 R2 full mask
      {3'd0, 32'h00F0_0000, 32'h0000_A503},  // R1 clear one nibble
      {3'd0, 32'h0F00_0F00, 32'h0000_AF03},  // R1 set one nibble
      {3'd1, 32'hFFFF_FFFF, 32'h0000_0C0F},  // R3 reserved bits stay 0
      {3'd1, 32'h0800_0000, 32'h0000_040F},  // R3 clear clk_inv[1]
      {3'd2, 32'hFFFF_00A6, 32'h0000_00A6},  // R4
      {3'd2, 32'h0001_FFFF, 32'h0000_00A7},  // R4 single bit
      {3'd3, 32'h07FF_045A, 32'h0000_045A},  // R5
      {3'd3, 32'h0000_FFFF, 32'h0000_045A}   // R1 zero mask
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic do_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_valid = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_valid = 1'b0;
      d = rd_data;
   endtask

   initial begin
      #400000;
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      chk("R8 test_clk", {31'd0, test_clk}, 32'd1);
      chk("R8 lane word out", {16'd0, turn_dis, force_stop, force_rx, lane_en}, 32'd0);
      chk("R8 dec_err", {31'd0, dec_err}, 32'd0);
      do_read(3'd3, r); chk("R8 test word read", r, 32'h0000_0200);
      do_read(3'd1, r); chk("R8 turn word read", r, 32'h0);

      for (int i = 0; i < 9; i++) begin
         do_write(VEC[i][66:64], VEC[i][63:32]);
         do_read(VEC[i][66:64], r);
         chk($sformatf("R1 vector %0d", i), r, VEC[i][31:0]);
      end

      // field positions at the pins
      chk("R2 lane fields", {16'd0, turn_dis, force_stop, force_rx, lane_en}, 32'h0000_AF03);
      chk("R3 turn_req/clk_inv", {26'd0, clk_inv, turn_req}, 32'h0000_001F);
      chk("R4 xcv fields", {24'd0, xcv_master, xcv_clk_en, xcv_base_dir, xcv_src_sel, xcv_turn_req},
          32'h0000_00A7);
      chk("R5 test fields", {21'd0, test_clr, test_clk, test_en, test_din}, 32'h0000_045A);

      // R6 status read and ignored write
      test_dout = 8'h3C;
      do_read(3'd4, r); chk("R6 status read", r, 32'h0000_003C);
      do_write(3'd4, 32'hFFFF_FFFF);
      chk("R6 no dec_err on status write", {31'd0, dec_err}, 32'd0);
      do_read(3'd0, r); chk("R6 status write left lane word", r, 32'h0000_AF03);
      do_read(3'd3, r); chk("R6 status write left test word", r, 32'h0000_045A);

      // R9 unmapped write
      do_write(3'd5, 32'hFFFF_FFFF);
      chk("R9 dec_err pulse", {31'd0, dec_err}, 32'd1);
      @(negedge clk);
      chk("R9 dec_err one cycle", {31'd0, dec_err}, 32'd0);
      do_read(3'd0, r); chk("R9 lane word kept", r, 32'h0000_AF03);
      do_read(3'd1, r); chk("R9 turn word kept", r, 32'h0000_040F);
      do_read(3'd2, r); chk("R9 xcv word kept", r, 32'h0000_00A7);

      // R7 unmapped read and hold
      do_read(3'd6, r); chk("R7 unmapped read zero", r, 32'h0);
      @(negedge clk); @(negedge clk);
      chk("R7 rd_data held", rd_data, 32'h0);

      // R10 same-cycle read and write
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = 3'd0; wr_data = 32'hFFFF_1234;
      rd_valid = 1'b1; rd_addr = 3'd0;
      @(negedge clk);
      wr_valid = 1'b0; rd_valid = 1'b0;
      chk("R10 read sees old value", rd_data, 32'h0000_AF03);
      chk("R10 outputs updated", {16'd0, turn_dis, force_stop, force_rx, lane_en}, 32'h0000_1234);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule